// File: doc/BRIEF.md
# Eight-Lane SIMD Datapath with Branch Masking

This block is one shader-core execution slice. Eight lanes each hold the context of one fragment, and all eight obey a single decoded instruction. The arithmetic is fixed-point: signed, `DW` bits wide, with `FRAC` fractional bits. The default is Q8.8, where 1.0 is `0x0100`. There are four arithmetic operations: multiply, multiply-add, clamp to the unit interval, and move. A load operation takes one fresh value per lane from a wide input bus.

Divergent `if/else` code is executed serially. A compare instruction records one true/false bit per lane. The taken path then runs with only the true lanes enabled, and the else path runs with only the false lanes enabled. A closing instruction restores the full set of lanes. There is one saved mask, so the nesting depth is one. If a path has no enabled lanes, its instructions are retired without occupying an issue slot. A running counter totals the enabled lanes over all issue cycles, so that lane efficiency can be computed as `util_total / (8 * issue_total)`.

Instructions arrive on a valid/ready stream. Results leave on a second valid/ready stream that carries the destination register, the lane mask and the per-lane data.
- An instruction is accepted on any edge where `in_valid && in_ready`.
- `in_ready` is high whenever the output register is empty or is being drained in the same cycle.
- While `wb_valid` is high and `wb_ready` is low, the output holds its values and the input stalls.

Top module: `simd_lane_array`

## Requirements
- R1: After reset:
  - every lane register reads zero;
  - `act_lanes` is 8;
  - `util_total` and `issue_total` are 0;
  - `wb_valid` is 0 and `in_ready` is 1.
- R2: Opcodes are LDI=1, MOV=2, MUL=3, MADD=4. Operand A is register `in_sa`. Operand B is `in_imm` when `in_bimm`=1, otherwise register `in_sb`. Operand C is register `in_sc`. The results are:
  - LDI writes the lane's `DW`-bit slice of `in_lane_data` (lane i at bits `i*DW +: DW`);
  - MOV writes B;
  - MUL writes `(A*B)>>>FRAC`, truncated to `DW` bits;
  - MADD writes that product plus C, truncated to `DW` bits.
- R3: CLMP (opcode 5) writes 0 when A is negative. It writes `1<<FRAC` when A exceeds 1.0. Otherwise it writes A unchanged.
- R4: IFGT (opcode 6) is accepted with no branch open. Each lane then evaluates signed A > B, and the active mask becomes those lanes (lane i is mask bit i). Later arithmetic writes only lanes whose mask bit is 1. Other lanes keep their registers and show zero in `wb_data`.
- R5: ELSE (opcode 7) inside the taken path enables exactly the lanes of the saved mask that failed the compare. ENDIF (opcode 8) inside either path re-enables all eight lanes.
- R6: An arithmetic instruction accepted while the active mask is all zeros writes no register. It raises no `wb_valid` and counts no issue cycle.
- R7: Each issued arithmetic instruction adds the number of enabled lanes to `util_total` and adds one to `issue_total`. `act_lanes` always shows the current enabled-lane count.
- R8: `in_ready` equals `!wb_valid || wb_ready`. While `wb_valid && !wb_ready`, every writeback output holds its value.
- R9: These control instructions are accepted and have no effect:
  - ELSE or ENDIF with no branch open;
  - IFGT while a branch is open;
  - ELSE on the else path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction beat valid |
| in_ready | output | 1 | Instruction beat accepted when high |
| in_op | input | 4 | Opcode |
| in_dst | input | log2(NREGS) | Destination register |
| in_sa | input | log2(NREGS) | Operand A register |
| in_sb | input | log2(NREGS) | Operand B register |
| in_sc | input | log2(NREGS) | Operand C register |
| in_bimm | input | 1 | Select immediate for operand B |
| in_imm | input | DW | Immediate constant shared by all lanes |
| in_lane_data | input | LANES*DW | Per-lane load values |
| wb_valid | output | 1 | Writeback beat valid |
| wb_ready | input | 1 | Writeback consumer ready |
| wb_dst | output | log2(NREGS) | Register written |
| wb_mask | output | LANES | Lanes that wrote |
| wb_data | output | LANES*DW | Per-lane results, zero for disabled lanes |
| act_lanes | output | log2(LANES+1) | Current enabled-lane count |
| util_total | output | CW | Accumulated enabled lanes over issue cycles |
| issue_total | output | CW | Number of issue cycles |

## Verification
The bench opens a branch whose compare is true in three lanes. Each path writes the same register, and the register is then read back with all lanes enabled. A design that let masked lanes write, or that built the else mask from the wrong set, returns wrong values in particular lanes.

An impossible compare leaves an empty path. A design that issued into that path would raise a spurious writeback or increment `issue_total`. Further cases cover:
- a single-lane path, which gives the one-in-eight utilization step;
- stray ELSE, ENDIF and nested IFGT instructions, which a wrong design would let corrupt the mask;
- a stalled writeback, where a wrong design would overwrite held data or keep accepting instructions.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_LDI   = 4'd1,
    OP_MOV   = 4'd2,
    OP_MUL   = 4'd3,
    OP_MADD  = 4'd4,
    OP_CLMP  = 4'd5,
    OP_IFGT  = 4'd6,
    OP_ELSE  = 4'd7,
    OP_ENDIF = 4'd8
  } op_e;

  typedef enum logic [1:0] {
    PH_UNIFORM = 2'd0,
    PH_TAKEN   = 2'd1,
    PH_OTHER   = 2'd2
  } phase_e;

  function automatic logic is_arith(input logic [3:0] op);
    return (op == OP_LDI) || (op == OP_MOV) || (op == OP_MUL) ||
           (op == OP_MADD) || (op == OP_CLMP);
  endfunction
endpackage

// File: rtl/simd_lane.sv
module simd_lane
  import simd_pkg::*;
#(
  parameter int DW    = 16,
  parameter int FRAC  = 8,
  parameter int NREGS = 8,
  parameter int RW    = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [3:0]    op,
  input  logic [RW-1:0] dst,
  input  logic [RW-1:0] sa,
  input  logic [RW-1:0] sb,
  input  logic [RW-1:0] sc,
  input  logic          b_imm,
  input  logic [DW-1:0] imm,
  input  logic [DW-1:0] ld_data,
  output logic [DW-1:0] res,
  output logic          gt
);
  localparam int            ONE_I = 1 << FRAC;
  localparam logic [DW-1:0] ONE   = ONE_I[DW-1:0];

  logic [DW-1:0]          rf [NREGS];
  logic [DW-1:0]          a_v, b_v, c_v, scaled;
  logic signed [2*DW-1:0] prod;

  always_comb begin
    a_v    = rf[sa];
    b_v    = b_imm ? imm : rf[sb];
    c_v    = rf[sc];
    prod   = $signed(a_v) * $signed(b_v);
    scaled = prod[FRAC +: DW];
    gt     = $signed(a_v) > $signed(b_v);
    case (op)
      OP_LDI:  res = ld_data;
      OP_MOV:  res = b_v;
      OP_MUL:  res = scaled;
      OP_MADD: res = scaled + c_v;
      OP_CLMP: begin
        if ($signed(a_v) < 0)                 res = '0;
        else if ($signed(a_v) > $signed(ONE)) res = ONE;
        else                                  res = a_v;
      end
      default: res = a_v;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREGS; r++) rf[r] <= '0;
    end else if (wr_en) begin
      rf[dst] <= res;
    end
  end
endmodule

// File: rtl/simd_mask_ctl.sv
module simd_mask_ctl
  import simd_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_fire,
  input  logic [3:0]       op,
  input  logic [LANES-1:0] cond,
  output logic [LANES-1:0] mask
);
  logic [LANES-1:0] mask_q, saved_q, cond_q;
  phase_e           phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '1;
      saved_q <= '1;
      cond_q  <= '0;
      phase_q <= PH_UNIFORM;
    end else if (ctl_fire) begin
      if (op == OP_IFGT && phase_q == PH_UNIFORM) begin
        saved_q <= mask_q;
        cond_q  <= cond;
        mask_q  <= mask_q & cond;
        phase_q <= PH_TAKEN;
      end else if (op == OP_ELSE && phase_q == PH_TAKEN) begin
        mask_q  <= saved_q & ~cond_q;
        phase_q <= PH_OTHER;
      end else if (op == OP_ENDIF && phase_q != PH_UNIFORM) begin
        mask_q  <= saved_q;
        phase_q <= PH_UNIFORM;
      end
    end
  end

  assign mask = mask_q;

  AST_UNIFORM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_UNIFORM) |-> (mask_q == {LANES{1'b1}}));  // R5
  AST_IF_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_fire && op == OP_IFGT && phase_q == PH_UNIFORM) |=> (mask_q == $past(cond)));  // R4
  AST_ELSE_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_fire && op == OP_ELSE && phase_q == PH_TAKEN) |=> ((mask_q & $past(mask_q)) == '0));  // R5
endmodule

// File: rtl/simd_util_ctr.sv
module simd_util_ctr #(
  parameter int LANES = 8,
  parameter int CW    = 32,
  parameter int NW    = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [LANES-1:0] mask,
  output logic [NW-1:0]    pop,
  output logic [CW-1:0]    util_o,
  output logic [CW-1:0]    issue_o
);
  always_comb begin
    pop = '0;
    for (int i = 0; i < LANES; i++) pop = pop + NW'(mask[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      util_o  <= '0;
      issue_o <= '0;
    end else if (issue) begin
      util_o  <= util_o + CW'(pop);
      issue_o <= issue_o + 1'b1;
    end
  end

  AST_UTIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> (util_o - $past(util_o)) == CW'($countones($past(mask))));  // R7
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> ($stable(util_o) && $stable(issue_o)));  // R6
endmodule

// File: rtl/simd_lane_array.sv
module simd_lane_array
  import simd_pkg::*;
#(
  parameter int LANES = 8,
  parameter int DW    = 16,
  parameter int FRAC  = 8,
  parameter int NREGS = 8,
  parameter int CW    = 32,
  parameter int RW    = $clog2(NREGS),
  parameter int NW    = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [3:0]          in_op,
  input  logic [RW-1:0]       in_dst,
  input  logic [RW-1:0]       in_sa,
  input  logic [RW-1:0]       in_sb,
  input  logic [RW-1:0]       in_sc,
  input  logic                in_bimm,
  input  logic [DW-1:0]       in_imm,
  input  logic [LANES*DW-1:0] in_lane_data,
  output logic                wb_valid,
  input  logic                wb_ready,
  output logic [RW-1:0]       wb_dst,
  output logic [LANES-1:0]    wb_mask,
  output logic [LANES*DW-1:0] wb_data,
  output logic [NW-1:0]       act_lanes,
  output logic [CW-1:0]       util_total,
  output logic [CW-1:0]       issue_total
);
  logic             fire, arith, issue, ctl_fire;
  logic [LANES-1:0] mask, cond;
  logic [DW-1:0]    res_w  [LANES];
  logic [DW-1:0]    data_q [LANES];

  assign in_ready = !wb_valid || wb_ready;
  assign fire     = in_valid && in_ready;
  assign arith    = is_arith(in_op);
  assign issue    = fire && arith && (|mask);
  assign ctl_fire = fire && !arith;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    simd_lane #(.DW(DW), .FRAC(FRAC), .NREGS(NREGS), .RW(RW)) lane_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (issue && mask[g]),
      .op     (in_op),
      .dst    (in_dst),
      .sa     (in_sa),
      .sb     (in_sb),
      .sc     (in_sc),
      .b_imm  (in_bimm),
      .imm    (in_imm),
      .ld_data(in_lane_data[g*DW +: DW]),
      .res    (res_w[g]),
      .gt     (cond[g])
    );
    assign wb_data[g*DW +: DW] = data_q[g];
  end

  simd_mask_ctl #(.LANES(LANES)) mask_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl_fire(ctl_fire),
    .op      (in_op),
    .cond    (cond),
    .mask    (mask)
  );

  simd_util_ctr #(.LANES(LANES), .CW(CW), .NW(NW)) util_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .issue  (issue),
    .mask   (mask),
    .pop    (act_lanes),
    .util_o (util_total),
    .issue_o(issue_total)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_dst   <= '0;
      wb_mask  <= '0;
      for (int i = 0; i < LANES; i++) data_q[i] <= '0;
    end else if (issue) begin
      wb_valid <= 1'b1;
      wb_dst   <= in_dst;
      wb_mask  <= mask;
      for (int i = 0; i < LANES; i++) data_q[i] <= mask[i] ? res_w[i] : '0;
    end else if (wb_ready) begin
      wb_valid <= 1'b0;
    end
  end

  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_data) && $stable(wb_mask) && $stable(wb_dst)));  // R8
  AST_WB_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_mask != '0));  // R6
  AST_EMPTY_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && arith && mask == '0 && wb_ready) |=> !wb_valid);  // R6
endmodule

// File: tb/simd_lane_array_tb_top.sv
module simd_lane_array_tb_top;
  import simd_pkg::*;
  localparam int L = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0, in_valid = 1'b0, in_ready, in_bimm = 1'b0;
  logic [3:0]    in_op = '0;
  logic [2:0]    in_dst = '0, in_sa = '0, in_sb = '0, in_sc = '0;
  logic [DW-1:0] in_imm = '0;
  logic [L*DW-1:0] in_lane_data = '0;
  logic          wb_valid, wb_ready = 1'b1;
  logic [2:0]    wb_dst;
  logic [L-1:0]  wb_mask;
  logic [L*DW-1:0] wb_data;
  logic [3:0]    act_lanes;
  logic [31:0]   util_total, issue_total;

  simd_lane_array dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_dst(in_dst), .in_sa(in_sa), .in_sb(in_sb), .in_sc(in_sc),
    .in_bimm(in_bimm), .in_imm(in_imm), .in_lane_data(in_lane_data),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_dst(wb_dst), .wb_mask(wb_mask),
    .wb_data(wb_data), .act_lanes(act_lanes), .util_total(util_total),
    .issue_total(issue_total)
  );

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;
  string cur_req = "R1";

  logic [DW-1:0] m_rf [L][8];
  logic [L-1:0]  m_mask, m_saved, m_cond, m_wb_mask;
  logic [DW-1:0] m_wb_data [L];
  int            m_phase, m_wb_dst;
  bit            m_wb_valid, m_last_fire;
  longint        m_util, m_issue;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ref_alu(logic [3:0] op, logic [DW-1:0] a, b, c, ld);
    longint sa, sb, sc, p;
    logic [DW-1:0] r;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    sc = longint'($signed(c));
    case (op)
      OP_LDI:  r = ld;
      OP_MOV:  r = b;
      OP_MUL:  begin p = (sa * sb) >>> 8; r = p[DW-1:0]; end
      OP_MADD: begin p = ((sa * sb) >>> 8) + sc; r = p[DW-1:0]; end
      OP_CLMP: r = (sa < 0) ? 16'h0000 : (sa > 256) ? 16'h0100 : a;
      default: r = a;
    endcase
    return r;
  endfunction

  // behavioural reference, stepped on every rising edge
  always @(posedge clk) begin
    logic [DW-1:0] bv;
    logic [L-1:0]  c;
    if (!rst_n) begin
      for (int l = 0; l < L; l++) begin
        for (int r = 0; r < 8; r++) m_rf[l][r] = '0;
        m_wb_data[l] = '0;
      end
      m_mask = '1; m_saved = '1; m_cond = '0; m_phase = 0;
      m_wb_valid = 0; m_wb_mask = '0; m_wb_dst = 0; m_util = 0; m_issue = 0;
      m_last_fire = 0;
    end else begin
      m_last_fire = 0;
      if (in_valid && (!m_wb_valid || wb_ready)) begin
        m_last_fire = 1;
        if (wb_ready) m_wb_valid = 0;
        if (in_op inside {OP_LDI, OP_MOV, OP_MUL, OP_MADD, OP_CLMP}) begin
          if (m_mask != 0) begin
            for (int l = 0; l < L; l++) begin
              bv = in_bimm ? in_imm : m_rf[l][in_sb];
              m_wb_data[l] = '0;
              if (m_mask[l]) begin
                m_wb_data[l] = ref_alu(in_op, m_rf[l][in_sa], bv, m_rf[l][in_sc],
                                       in_lane_data[l*DW +: DW]);
                m_rf[l][in_dst] = m_wb_data[l];
              end
            end
            m_wb_valid = 1; m_wb_mask = m_mask; m_wb_dst = in_dst;
            m_util += $countones(m_mask); m_issue++;
          end
        end else if (in_op == OP_IFGT && m_phase == 0) begin
          for (int l = 0; l < L; l++) begin
            bv = in_bimm ? in_imm : m_rf[l][in_sb];
            c[l] = $signed(m_rf[l][in_sa]) > $signed(bv);
          end
          m_saved = m_mask; m_cond = c; m_mask = m_mask & c; m_phase = 1;
        end else if (in_op == OP_ELSE && m_phase == 1) begin
          m_mask = m_saved & ~m_cond; m_phase = 2;
        end else if (in_op == OP_ENDIF && m_phase != 0) begin
          m_mask = m_saved; m_phase = 0;
        end
      end else if (wb_ready) begin
        m_wb_valid = 0;
      end
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk(cur_req, "in_ready", in_ready, !m_wb_valid || wb_ready);
      chk(cur_req, "act_lanes", act_lanes, $countones(m_mask));
      chk(cur_req, "util_total", util_total, m_util);
      chk(cur_req, "issue_total", issue_total, m_issue);
      chk(cur_req, "wb_valid", wb_valid, m_wb_valid);
      if (m_wb_valid) begin
        chk(cur_req, "wb_dst", wb_dst, m_wb_dst);
        chk(cur_req, "wb_mask", wb_mask, m_wb_mask);
        for (int l = 0; l < L; l++)
          chk(cur_req, $sformatf("wb_data lane%0d", l), wb_data[l*DW +: DW], m_wb_data[l]);
      end
    end
  end

  task automatic issue(logic [3:0] op, int dst, int sa, int sb, int sc, bit bimm, logic [DW-1:0] imm);
    @(negedge clk);
    in_op = op; in_dst = dst[2:0]; in_sa = sa[2:0]; in_sb = sb[2:0]; in_sc = sc[2:0];
    in_bimm = bimm; in_imm = imm; in_valid = 1'b1;
    do @(negedge clk); while (!m_last_fire);
    in_valid = 1'b0;
    #3;
  endtask

  function automatic logic [DW-1:0] lane_of(logic [L*DW-1:0] v, int l);
    return v[l*DW +: DW];
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=<50000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    longint u0, i0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #3;
    // R1 reset state
    chk("R1", "act_lanes", act_lanes, 8);
    chk("R1", "util_total", util_total, 0);
    chk("R1", "issue_total", issue_total, 0);
    chk("R1", "wb_valid", wb_valid, 0);
    chk("R1", "in_ready", in_ready, 1);
    issue(OP_MOV, 0, 0, 4, 0, 0, 16'h0);
    chk("R1", "reg4 lane6 zero", lane_of(wb_data, 6), 0);

    // R2 arithmetic
    cur_req = "R2";
    in_lane_data = {16'hFFFF, 16'hFE00, 16'hFF00, 16'h0000, 16'hFFC0, 16'h0080, 16'h0100, 16'h0180};
    issue(OP_LDI, 1, 0, 0, 0, 0, 16'h0);
    chk("R2", "ldi lane3", lane_of(wb_data, 3), 16'hFFC0);
    in_lane_data = {16'h8000, 16'h0300, 16'h0010, 16'h7FFF, 16'h0040, 16'hFF80, 16'h0200, 16'h0100};
    issue(OP_LDI, 2, 0, 0, 0, 0, 16'h0);
    issue(OP_MUL, 3, 1, 2, 0, 0, 16'h0);
    chk("R2", "mul lane0", lane_of(wb_data, 0), 16'h0180);
    issue(OP_MADD, 4, 1, 0, 2, 1, 16'h0180);
    chk("R2", "madd lane0", lane_of(wb_data, 0), 16'h0340);
    issue(OP_MOV, 6, 0, 0, 0, 1, 16'h1234);
    chk("R2", "mov imm lane5", lane_of(wb_data, 5), 16'h1234);

    // R3 clamp
    cur_req = "R3";
    issue(OP_CLMP, 5, 1, 0, 0, 0, 16'h0);
    chk("R3", "clamp high lane0", lane_of(wb_data, 0), 16'h0100);
    chk("R3", "clamp neg lane3", lane_of(wb_data, 3), 16'h0000);
    chk("R3", "clamp mid lane2", lane_of(wb_data, 2), 16'h0080);
    issue(OP_CLMP, 5, 4, 0, 0, 0, 16'h0);

    // R4 / R5 divergent branch, TTTFFFFF
    cur_req = "R4";
    issue(OP_MOV, 7, 0, 0, 0, 1, 16'h0555);
    issue(OP_IFGT, 0, 1, 0, 0, 1, 16'h0000);
    chk("R4", "taken act_lanes", act_lanes, 3);
    issue(OP_MUL, 7, 1, 0, 0, 1, 16'h0200);
    chk("R4", "taken wb_mask", wb_mask, 8'h07);
    chk("R4", "taken lane0", lane_of(wb_data, 0), 16'h0300);
    chk("R4", "masked lane4 data", lane_of(wb_data, 4), 16'h0000);
    cur_req = "R5";
    issue(OP_ELSE, 0, 0, 0, 0, 0, 16'h0);
    chk("R5", "else act_lanes", act_lanes, 5);
    issue(OP_MOV, 7, 0, 0, 0, 1, 16'h0080);
    chk("R5", "else wb_mask", wb_mask, 8'hF8);
    issue(OP_ENDIF, 0, 0, 0, 0, 0, 16'h0);
    chk("R5", "endif act_lanes", act_lanes, 8);
    issue(OP_MOV, 0, 0, 7, 0, 0, 16'h0);
    chk("R4", "readback lane1", lane_of(wb_data, 1), 16'h0200);
    chk("R5", "readback lane7", lane_of(wb_data, 7), 16'h0080);

    // R6 empty path
    cur_req = "R6";
    issue(OP_IFGT, 0, 1, 0, 0, 1, 16'h7000);
    chk("R6", "empty act_lanes", act_lanes, 0);
    i0 = issue_total;
    issue(OP_MUL, 7, 1, 1, 0, 0, 16'h0);
    chk("R6", "no issue count", issue_total, i0);
    chk("R6", "no writeback", wb_valid, 0);
    issue(OP_ELSE, 0, 0, 0, 0, 0, 16'h0);
    chk("R6", "else all lanes", act_lanes, 8);
    issue(OP_ENDIF, 0, 0, 0, 0, 0, 16'h0);
    issue(OP_MOV, 0, 0, 7, 0, 0, 16'h0);
    chk("R6", "reg7 untouched lane0", lane_of(wb_data, 0), 16'h0300);

    // R7 single-lane worst case
    cur_req = "R7";
    issue(OP_IFGT, 0, 1, 0, 0, 1, 16'h012C);
    chk("R7", "one lane", act_lanes, 1);
    u0 = util_total;
    issue(OP_MOV, 6, 0, 0, 0, 1, 16'h0001);
    chk("R7", "util step one", util_total - u0, 1);
    issue(OP_ENDIF, 0, 0, 0, 0, 0, 16'h0);

    // R9 stray control
    cur_req = "R9";
    issue(OP_ENDIF, 0, 0, 0, 0, 0, 16'h0);
    chk("R9", "stray endif", act_lanes, 8);
    issue(OP_ELSE, 0, 0, 0, 0, 0, 16'h0);
    chk("R9", "stray else", act_lanes, 8);
    issue(OP_IFGT, 0, 1, 0, 0, 1, 16'h0000);
    issue(OP_IFGT, 0, 1, 0, 0, 1, 16'h012C);
    chk("R9", "nested if ignored", act_lanes, 3);
    issue(OP_ELSE, 0, 0, 0, 0, 0, 16'h0);
    issue(OP_ELSE, 0, 0, 0, 0, 0, 16'h0);
    chk("R9", "second else ignored", act_lanes, 5);
    issue(OP_ENDIF, 0, 0, 0, 0, 0, 16'h0);
    chk("R9", "closed", act_lanes, 8);

    // R8 back-pressure
    cur_req = "R8";
    @(negedge clk) wb_ready = 1'b0;
    issue(OP_MOV, 6, 0, 0, 0, 1, 16'h0111);
    @(negedge clk);
    in_op = OP_MOV; in_dst = 3'd6; in_bimm = 1'b1; in_imm = 16'h0222; in_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #3;
      chk("R8", "stalled in_ready", in_ready, 0);
      chk("R8", "held lane0", lane_of(wb_data, 0), 16'h0111);
    end
    wb_ready = 1'b1;
    do @(negedge clk); while (!m_last_fire);
    in_valid = 1'b0;
    #3;
    chk("R8", "new lane0", lane_of(wb_data, 0), 16'h0222);

    cur_req = "R7";
    repeat (2) @(negedge clk);
    #3;
    chk("R7", "util total", util_total, m_util);
    chk("R7", "issue total", issue_total, m_issue);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule